// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a 4096-bit nonvolatile memory that a host reaches over a three-wire serial link: a select line, a serial clock, a data-in line and a data-out line. A static organization input selects either 256 words of 16 bits or 512 bytes. The host raises select and clocks in a start bit, a two-bit opcode, an address and, for storing commands, a data field. The block then reads a word, programs or clears one location or the whole array, or sets or clears an internal latch that guards every programming command.

After each accepted programming command the block is busy for a fixed number of system clocks. A host that selects the device in that time sees the busy state on the data-out line, and the ready state once it ends. A single 1 clocked in afterwards releases the line. The data-out pin comes as a value plus a separate output enable, so that a pad or a shared data line can be built around it.

The serial clock is sampled in the system clock domain. It is assumed to be synchronous to that domain and to stay high and low for at least two system clocks each.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output enable is low, the program latch is disabled and no busy period is running.
- R2: Rising serial clock edges with data-in 0 before the start bit are ignored; an instruction begins at the first rising edge with data-in 1 while select is high.
- R3: Fields enter MSB first on rising serial clock edges: after the start bit, a 2-bit opcode (10 read, 01 write, 11 erase, 00 special), then 8 address bits and 16 data bits when `org_x16` is 1, or 9 address bits and 8 data bits when it is 0.
- R4: For opcode 00 the two top address bits pick the command: 11 enables programming, 00 disables it, 10 clears all locations, 01 writes the following data to all locations; the other address bits are ignored.
- R5: While the program latch is disabled, write, erase, clear-all and write-all leave memory unchanged and start no busy period.
- R6: On a read, the output is enabled and driven 0 from the edge of the last address bit; each later rising edge presents the next data bit, MSB first, and 0 once the word is exhausted.
- R7: An accepted write stores its data at the addressed location; an accepted erase or clear-all sets the addressed word, or every location, to all ones.
- R8: An accepted programming command starts a busy period of `BUSY_CYCLES` system clocks; while select is high afterwards the output is enabled and reads 0 while busy and 1 once ready.
- R9: With the status shown, a rising serial clock edge with data-in 1 disables the output within two system clocks.
- R10: Lowering select aborts a partly shifted instruction without effect, and the output is disabled whenever select is low.
- R11: In byte organization, byte address 2k holds the upper byte of word k and byte address 2k+1 its lower byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| org_x16 | input | 1 | Organization: 1 = 256 x 16, 0 = 512 x 8 (static) |
| cs | input | 1 | Device select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| do_out | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for data out |

## Verification
Word patterns with the top bit alone set, all zeros, all ones and alternating bits are written and read back, which separates a bit-order or field-offset error from a stuck data path. The same storage is reached in both organizations, so a byte address that lands on the wrong half of a word shows up as a wrong read in the other mode. Special commands are sent with the don't-care address bits set and cleared in turn, and programming is tried with the latch both set and cleared, which tells a missed guard apart from a wrong command decode. Partial instructions cut off by select, leading zeros before the start bit, and status polling right after a command and after the release bit cover the framing and the busy handshake.

// File: rtl/mw_pkg.sv
// Package: shared types for the serial EEPROM slave.
// Holds the shift-in state encoding, the decoded command kinds and the
// two-bit opcode values seen on the serial line.
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_HOLD
    } mw_state_e;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_EWEN,
        CMD_EWDS,
        CMD_ERAL,
        CMD_WRAL
    } mw_cmd_e;

    localparam logic [1:0] OPC_SPECIAL = 2'b00;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_ERASE   = 2'b11;

    localparam logic [1:0] SUB_EWDS = 2'b00;
    localparam logic [1:0] SUB_WRAL = 2'b01;
    localparam logic [1:0] SUB_ERAL = 2'b10;
    localparam logic [1:0] SUB_EWEN = 2'b11;

endpackage

// File: rtl/mw_decoder.sv
// Module: mw_decoder
// Shifts in start bit, opcode, address and data on serial clock rises and
// emits one registered command pulse once the last field bit has arrived.
// Assumes sk_rise is a one-clock pulse and that org_x16 is static during a
// transaction. Leaving select returns it to idle and drops partial input.
module mw_decoder
    import mw_pkg::*;
#(
    parameter int WORD_AW = 8,
    parameter int WORD_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               sk_rise,
    input  logic               di,
    input  logic               org_x16,
    input  logic               hold_off,
    input  logic               stat_en,
    output logic               stat_clr,
    output logic               cmd_valid,
    output mw_cmd_e            cmd_kind,
    output logic [WORD_AW:0]   cmd_addr,
    output logic [WORD_W-1:0]  cmd_data
);
    localparam int BYTE_AW = WORD_AW + 1;
    localparam int HALF_W  = WORD_W / 2;
    localparam int CNT_W   = $clog2(WORD_W + BYTE_AW + 1);

    mw_state_e            state;
    logic [1:0]           op;
    logic [BYTE_AW-2:0]   addr_sh;
    logic [WORD_W-2:0]    data_sh;
    logic [CNT_W-1:0]     cnt;

    logic [BYTE_AW-1:0]   addr_next;
    logic [WORD_W-1:0]    data_next;
    logic [CNT_W-1:0]     addr_last;
    logic [CNT_W-1:0]     data_last;
    logic [1:0]           sub;
    logic [BYTE_AW-1:0]   addr_eff;
    logic [WORD_W-1:0]    data_eff;
    mw_cmd_e              kind_dec;

    // Field lengths, special sub-code and masked address for this organization.
    always_comb begin
        addr_next = {addr_sh, di};
        data_next = {data_sh, di};
        addr_last = org_x16 ? CNT_W'(WORD_AW - 1) : CNT_W'(BYTE_AW - 1);
        data_last = org_x16 ? CNT_W'(WORD_W - 1)  : CNT_W'(HALF_W - 1);
        sub       = org_x16 ? addr_next[WORD_AW-1 -: 2] : addr_next[BYTE_AW-1 -: 2];
        addr_eff  = org_x16 ? {1'b0, addr_next[WORD_AW-1:0]} : addr_next;
        data_eff  = org_x16 ? data_next : {{HALF_W{1'b0}}, data_next[HALF_W-1:0]};
        case (op)
            OPC_READ:  kind_dec = CMD_READ;
            OPC_WRITE: kind_dec = CMD_WRITE;
            OPC_ERASE: kind_dec = CMD_ERASE;
            default: begin
                case (sub)
                    SUB_EWEN: kind_dec = CMD_EWEN;
                    SUB_ERAL: kind_dec = CMD_ERAL;
                    SUB_WRAL: kind_dec = CMD_WRAL;
                    default:  kind_dec = CMD_EWDS;
                endcase
            end
        endcase
    end

    // Shift-in state machine; one step per serial clock rise while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op        <= '0;
            addr_sh   <= '0;
            data_sh   <= '0;
            cnt       <= '0;
            stat_clr  <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_kind  <= CMD_READ;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            stat_clr  <= 1'b0;
            if (!cs) begin
                state <= ST_IDLE;
            end else if (sk_rise) begin
                case (state)
                    ST_IDLE: begin
                        if (di) begin
                            if (stat_en) begin
                                stat_clr <= 1'b1;
                            end else if (!hold_off) begin
                                state <= ST_OPC;
                                cnt   <= '0;
                            end
                        end
                    end
                    ST_OPC: begin
                        op <= {op[0], di};
                        if (cnt == CNT_W'(1)) begin
                            state <= ST_ADDR;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        addr_sh <= addr_next[BYTE_AW-2:0];
                        if (cnt == addr_last) begin
                            cmd_addr <= addr_eff;
                            cmd_kind <= kind_dec;
                            cnt      <= '0;
                            if (kind_dec == CMD_WRITE || kind_dec == CMD_WRAL) begin
                                state <= ST_DATA;
                            end else begin
                                cmd_valid <= 1'b1;
                                state     <= (kind_dec == CMD_READ) ? ST_READ : ST_HOLD;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        data_sh <= data_next[WORD_W-2:0];
                        if (cnt == data_last) begin
                            cmd_data  <= data_eff;
                            cmd_valid <= 1'b1;
                            state     <= ST_HOLD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: leaving idle needs a selected rise carrying a 1 with no status shown.
    p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPC && $past(state) == ST_IDLE) |-> $past(sk_rise && di && cs && !stat_en))
        else $error("start without a start bit");

    // R3: a command only issues after its address or data field completed.
    p_cmd_after_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(state) == ST_ADDR || $past(state) == ST_DATA))
        else $error("command issued outside a field");

endmodule

// File: rtl/mw_array.sv
// Module: mw_array
// Byte-wide storage of 2**(WORD_AW+1) bytes. In word organization a word
// occupies an even byte (upper half) and the next odd byte (lower half).
// Nonvolatile in intent, so it has no reset. Reads are combinational.
module mw_array #(
    parameter int WORD_AW = 8,
    parameter int WORD_W  = 16
) (
    input  logic               clk,
    input  logic               org_x16,
    input  logic               we_one,
    input  logic               we_all,
    input  logic [WORD_AW:0]   waddr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [WORD_AW:0]   raddr,
    output logic [WORD_W-1:0]  rdata
);
    localparam int BYTE_AW = WORD_AW + 1;
    localparam int HALF_W  = WORD_W / 2;
    localparam int DEPTH   = 1 << BYTE_AW;

    logic [HALF_W-1:0] mem [DEPTH];

    // Single-location or whole-array write, one system clock.
    always_ff @(posedge clk) begin
        if (we_all) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (org_x16 && !i[0]) mem[i] <= wdata[WORD_W-1:HALF_W];
                else                  mem[i] <= wdata[HALF_W-1:0];
            end
        end else if (we_one) begin
            if (org_x16) begin
                mem[{waddr[WORD_AW-1:0], 1'b0}] <= wdata[WORD_W-1:HALF_W];
                mem[{waddr[WORD_AW-1:0], 1'b1}] <= wdata[HALF_W-1:0];
            end else begin
                mem[waddr] <= wdata[HALF_W-1:0];
            end
        end
    end

    // Read word, left-justified so the serial output always starts at the MSB.
    always_comb begin
        if (org_x16) rdata = {mem[{raddr[WORD_AW-1:0], 1'b0}], mem[{raddr[WORD_AW-1:0], 1'b1}]};
        else         rdata = {mem[raddr], {HALF_W{1'b0}}};
    end

endmodule

// File: rtl/mw_exec.sv
// Module: mw_exec
// Executes decoded commands: keeps the program latch, gates programming,
// times the busy period, shows ready/busy status and shifts read data out.
// Assumes consecutive serial clock rises are at least two clocks apart.
module mw_exec
    import mw_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int BUSY_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               sk_rise,
    input  logic               cmd_valid,
    input  mw_cmd_e            cmd_kind,
    input  logic [WORD_W-1:0]  cmd_data,
    input  logic               stat_clr,
    input  logic [WORD_W-1:0]  rdata,
    output logic               we_one,
    output logic               we_all,
    output logic [WORD_W-1:0]  wdata,
    output logic               busy,
    output logic               stat_en,
    output logic               do_out,
    output logic               do_oe
);
    localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);

    logic              wen_q;
    logic [BCNT_W-1:0] busy_cnt;
    logic              rd_act;
    logic [WORD_W-1:0] rd_sh;
    logic              rd_bit;
    logic              is_prog;
    logic              accept;

    // Programming gate and write data selection.
    always_comb begin
        is_prog = (cmd_kind == CMD_WRITE) || (cmd_kind == CMD_ERASE) ||
                  (cmd_kind == CMD_ERAL)  || (cmd_kind == CMD_WRAL);
        accept  = cmd_valid && is_prog && wen_q;
        we_one  = accept && (cmd_kind == CMD_WRITE || cmd_kind == CMD_ERASE);
        we_all  = accept && (cmd_kind == CMD_ERAL  || cmd_kind == CMD_WRAL);
        wdata   = (cmd_kind == CMD_ERASE || cmd_kind == CMD_ERAL) ? '1 : cmd_data;
        busy    = (busy_cnt != '0);
        do_oe   = cs && (rd_act || stat_en);
        do_out  = rd_act ? rd_bit : !busy;
    end

    // Latch, busy timer, status flag and read shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q    <= 1'b0;
            busy_cnt <= '0;
            stat_en  <= 1'b0;
            rd_act   <= 1'b0;
            rd_sh    <= '0;
            rd_bit   <= 1'b0;
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
            if (cmd_valid) begin
                case (cmd_kind)
                    CMD_EWEN: wen_q <= 1'b1;
                    CMD_EWDS: wen_q <= 1'b0;
                    CMD_READ: begin
                        rd_act <= 1'b1;
                        rd_sh  <= rdata;
                        rd_bit <= 1'b0;
                    end
                    default: begin
                        if (wen_q) begin
                            busy_cnt <= BCNT_W'(BUSY_CYCLES);
                            stat_en  <= 1'b1;
                        end
                    end
                endcase
            end
            if (stat_clr) stat_en <= 1'b0;
            if (!cs) begin
                rd_act <= 1'b0;
            end else if (rd_act && sk_rise) begin
                rd_bit <= rd_sh[WORD_W-1];
                rd_sh  <= {rd_sh[WORD_W-2:0], 1'b0};
            end
        end
    end

    // R5: a guarded command with the latch cleared leaves the timer idle.
    p_locked_no_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_prog && !wen_q) |=> !busy)
        else $error("busy started while locked");

    // R8: a busy period only begins right after a command pulse.
    p_busy_from_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid))
        else $error("busy without command");

    // R4: the latch is only cleared by the disable command.
    p_latch_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wen_q) |-> $past(cmd_valid && cmd_kind == CMD_EWDS))
        else $error("latch cleared without disable command");

endmodule

// File: rtl/mw_eeprom.sv
// Module: mw_eeprom (top)
// Serial EEPROM slave: detects serial clock rises in the system clock
// domain and ties the decoder, the executor and the storage together.
// Assumes sk, cs and di are synchronous to clk.
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int WORD_AW     = 8,
    parameter int WORD_W      = 16,
    parameter int BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org_x16,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_out,
    output logic do_oe
);
    logic              sk_q;
    logic              sk_rise;
    logic              stat_clr;
    logic              cmd_valid;
    mw_cmd_e           cmd_kind;
    logic [WORD_AW:0]  cmd_addr;
    logic [WORD_W-1:0] cmd_data;
    logic              busy;
    logic              stat_en;
    logic              we_one;
    logic              we_all;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] rdata;

    // Serial clock edge detector; resets high so a held-high clock gives no rise.
    always_ff @(posedge clk) begin
        if (!rst_n) sk_q <= 1'b1;
        else        sk_q <= sk;
    end
    assign sk_rise = sk && !sk_q;

    mw_decoder #(.WORD_AW(WORD_AW), .WORD_W(WORD_W)) dec_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk_rise(sk_rise), .di(di),
        .org_x16(org_x16), .hold_off(busy), .stat_en(stat_en),
        .stat_clr(stat_clr), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    mw_exec #(.WORD_W(WORD_W), .BUSY_CYCLES(BUSY_CYCLES)) exe_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk_rise(sk_rise),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_data(cmd_data),
        .stat_clr(stat_clr), .rdata(rdata), .we_one(we_one), .we_all(we_all),
        .wdata(wdata), .busy(busy), .stat_en(stat_en),
        .do_out(do_out), .do_oe(do_oe)
    );

    mw_array #(.WORD_AW(WORD_AW), .WORD_W(WORD_W)) mem_i (
        .clk(clk), .org_x16(org_x16), .we_one(we_one), .we_all(we_all),
        .waddr(cmd_addr), .wdata(wdata), .raddr(cmd_addr), .rdata(rdata)
    );

endmodule

// File: tb/mw_eeprom_tb.sv
// Directed bench for mw_eeprom: one task per scenario, each checking itself.
module mw_eeprom_tb_top;
    localparam int BUSY = 16;

    logic clk = 1'b0;
    logic rst_n, org_x16, cs, sk, di;
    logic do_out, do_oe;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    always #2 clk = ~clk;

    mw_eeprom #(.WORD_AW(8), .WORD_W(16), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .cs(cs), .sk(sk),
        .di(di), .do_out(do_out), .do_oe(do_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        di = b; clk_n(1);
        sk = 1'b1; clk_n(2);
        sk = 1'b0; clk_n(2);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    function automatic int aw();
        return org_x16 ? 8 : 9;
    endfunction

    function automatic int dw();
        return org_x16 ? 16 : 8;
    endfunction

    task automatic sel();
        cs = 1'b1; clk_n(1);
    endtask

    task automatic desel();
        cs = 1'b0; di = 1'b0; clk_n(2);
    endtask

    task automatic issue(input logic [1:0] op, input logic [8:0] a, input int lead);
        sel();
        for (int i = 0; i < lead; i++) pulse(1'b0);
        pulse(1'b1);
        send({30'd0, op}, 2);
        send({23'd0, a}, aw());
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        issue(2'b01, a, 0);
        send({16'd0, d}, dw());
        desel();
    endtask

    task automatic erase(input logic [8:0] a);
        issue(2'b11, a, 0);
        desel();
    endtask

    // Special command; filler sets every don't-care address bit to that value.
    task automatic special(input logic [1:0] sub, input logic filler, input logic [15:0] d);
        logic [8:0] a;
        a = filler ? 9'h1FF : 9'h000;
        if (org_x16) a[7:6] = sub; else a[8:7] = sub;
        issue(2'b00, a, 0);
        if (sub == 2'b01) send({16'd0, d}, dw());
        desel();
    endtask

    task automatic wait_ready(input string req);
        int n;
        sel();
        chk({req, " status shown"}, {31'd0, do_oe}, 32'd1);
        n = 0;
        while (do_out !== 1'b1 && n < 200) begin clk_n(1); n++; end
        chk({req, " ready reached"}, {31'd0, do_out}, 32'd1);
        pulse(1'b1);
        chk("R9 release after dummy 1", {31'd0, do_oe}, 32'd0);
        desel();
    endtask

    task automatic rd(input logic [8:0] a, input int lead, output logic [15:0] w);
        issue(2'b10, a, lead);
        chk("R6 dummy bit enabled", {31'd0, do_oe}, 32'd1);
        chk("R6 dummy bit value", {31'd0, do_out}, 32'd0);
        w = '0;
        for (int i = 0; i < dw(); i++) begin
            pulse(1'b0);
            w = {w[14:0], do_out};
        end
    endtask

    task automatic rd_chk(input string req, input logic [8:0] a, input logic [15:0] exp);
        logic [15:0] w;
        rd(a, 0, w);
        desel();
        chk(req, {16'd0, w}, {16'd0, exp});
    endtask

    task automatic t_reset();
        chk("R1 oe low after reset", {31'd0, do_oe}, 32'd0);
        sel();
        chk("R1 no status after reset", {31'd0, do_oe}, 32'd0);
        desel();
    endtask

    task automatic t_lock();
        org_x16 = 1'b1;
        wr(9'd5, 16'h1234);
        sel();
        chk("R5 locked write starts no busy", {31'd0, do_oe}, 32'd0);
        desel();
        special(2'b11, 1'b0, 16'h0);
        wr(9'd5, 16'hA5A5);
        sel();
        chk("R8 busy shown low", {30'd0, do_oe, do_out}, 32'd2);
        desel();
        wait_ready("R8");
        rd_chk("R7 write stored", 9'd5, 16'hA5A5);
        special(2'b00, 1'b1, 16'h0);
        wr(9'd5, 16'h1234);
        sel();
        chk("R5 locked write no status", {31'd0, do_oe}, 32'd0);
        desel();
        erase(9'd5);
        rd_chk("R5 locked write and erase ignored", 9'd5, 16'hA5A5);
        special(2'b11, 1'b1, 16'h0);
    endtask

    task automatic t_busy_len();
        int n;
        wr(9'd9, 16'h0F0F);
        sel();
        n = 0;
        while (do_out !== 1'b1 && n < 200) begin clk_n(1); n++; end
        chk("R8 busy period within bound", {31'd0, (n > 0 && n <= BUSY)}, 32'd1);
        pulse(1'b1);
        desel();
    endtask

    task automatic t_patterns();
        logic [15:0] pats [4] = '{16'h8000, 16'h0000, 16'hFFFF, 16'h5AA5};
        logic [8:0]  adrs [4] = '{9'd1, 9'd2, 9'd128, 9'd255};
        logic [15:0] w;
        for (int i = 0; i < 4; i++) begin
            wr(adrs[i], pats[i]);
            wait_ready("R8");
        end
        for (int i = 0; i < 4; i++) rd_chk("R7 pattern read back", adrs[i], pats[i]);
        rd(9'd1, 0, w);
        pulse(1'b0);
        chk("R6 zero after word", {31'd0, do_out}, 32'd0);
        desel();
        chk("R6 msb first", {16'd0, w}, 32'h8000);
    endtask

    task automatic t_erase();
        erase(9'd2);
        wait_ready("R8");
        rd_chk("R7 erase sets ones", 9'd2, 16'hFFFF);
    endtask

    task automatic t_all();
        special(2'b01, 1'b1, 16'h5A3C);
        wait_ready("R8");
        rd_chk("R4 write-all word 0", 9'd0, 16'h5A3C);
        rd_chk("R4 write-all word 128", 9'd128, 16'h5A3C);
        rd_chk("R7 write-all word 255", 9'd255, 16'h5A3C);
        special(2'b10, 1'b0, 16'h0);
        wait_ready("R8");
        rd_chk("R4 clear-all word 3", 9'd3, 16'hFFFF);
        rd_chk("R7 clear-all word 255", 9'd255, 16'hFFFF);
    endtask

    task automatic t_x8();
        org_x16 = 1'b0;
        wr(9'h014, 16'h0012);
        wait_ready("R8");
        wr(9'h015, 16'h0034);
        wait_ready("R8");
        wr(9'h1FF, 16'h00C3);
        wait_ready("R8");
        rd_chk("R3 byte read 0x14", 9'h014, 16'h0012);
        rd_chk("R3 byte read 0x1FF", 9'h1FF, 16'h00C3);
        org_x16 = 1'b1;
        rd_chk("R11 word 10 from bytes", 9'd10, 16'h1234);
        org_x16 = 1'b0;
        special(2'b10, 1'b1, 16'h0);
        wait_ready("R8");
        rd_chk("R4 clear-all in byte mode", 9'h015, 16'h00FF);
        org_x16 = 1'b1;
    endtask

    task automatic t_abort();
        logic [15:0] w;
        wr(9'd7, 16'h1111);
        wait_ready("R8");
        sel();
        pulse(1'b1);
        send(32'd1, 2);
        send(32'h7, 4);
        cs = 1'b0; clk_n(1);
        chk("R10 oe low when deselected", {31'd0, do_oe}, 32'd0);
        desel();
        sel();
        chk("R10 aborted write starts nothing", {31'd0, do_oe}, 32'd0);
        desel();
        rd_chk("R10 aborted write left data", 9'd7, 16'h1111);
        rd(9'd7, 3, w);
        desel();
        chk("R2 leading zeros ignored", {16'd0, w}, 32'h1111);
    endtask

    initial begin
        rst_n = 1'b0; org_x16 = 1'b1; cs = 1'b0; sk = 1'b0; di = 1'b0;
        clk_n(4);
        rst_n = 1'b1;
        clk_n(2);
        t_reset();
        t_lock();
        t_busy_len();
        t_patterns();
        t_erase();
        t_all();
        t_x8();
        t_abort();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule